// File: doc/BRIEF.md
# External Bus Cycle Length Controller

This block sets how long each cycle on an 8-bit microcontroller's external bus lasts. It holds one 8-bit control register that software writes and reads back. The register sets a separate wait code for data writes, data reads and code fetches. It also holds two enable bits that go straight out to a prefetch queue and a branch cache, which live outside this block.

The core presents a request with a cycle kind and a flag marking a code read made by a table-lookup instruction. While the block is idle it accepts the request and works out the cycle length from the wait code for that kind. It then drives the matching strobe (write, read or code) for that many clocks, with a one-clock done pulse in the last clock. The length is fixed when the request is accepted, so writing the register mid-cycle cannot stretch or cut short a cycle already running.

Top module: `extBusTimer`

## Requirements
- R1: After reset the control register reads back 0xEB and both enable outputs are high.
- R2: Register bit 7 drives `prefetchEn` and bit 6 drives `branchCacheEn` (1 = on). A register write is visible on `cfgRdData` and on the enables from the clock after the write edge.
- R3: A write cycle (kind 00) lasts 4 + W clocks, where W is register bits 5:4 read as an unsigned number (4 to 7 clocks).
- R4: A read cycle (kind 01) lasts 4 + D clocks, where D is register bits 3:2 (4 to 7 clocks).
- R5: A code cycle (kind 10) lasts 3 + C clocks, where C is register bits 1:0 (3 to 6 clocks). The one exception is C = 00 with `reqTable` high, which gives 4 clocks.
- R6: A register write made during a cycle does not change that cycle's length. The new value applies to cycles accepted after the write.
- R7: A request is accepted only on a clock edge where `busIdle` is high, and its strobe rises in the next clock. Requests made while busy, and requests of kind 11, are ignored.
- R8: `cycleDone` is high for exactly one clock, the last clock of the cycle.
- R9: At most one strobe is high at a time. It stays high through every clock of its cycle, and all strobes are low while `busIdle` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | Control register write enable |
| cfgWrData | input | 8 | Control register write data |
| cfgRdData | output | 8 | Control register contents |
| reqValid | input | 1 | Bus cycle request |
| reqKind | input | 2 | 00 write, 01 read, 10 code, 11 no cycle |
| reqTable | input | 1 | Code read made by a table-lookup instruction |
| busIdle | output | 1 | No cycle in progress; a request can be accepted |
| wrStrobe | output | 1 | Write strobe |
| rdStrobe | output | 1 | Read strobe |
| codeStrobe | output | 1 | Code fetch strobe |
| cycleDone | output | 1 | High in the last clock of a cycle |
| prefetchEn | output | 1 | Prefetch queue enable |
| branchCacheEn | output | 1 | Branch cache enable |

## Verification
The bench measures strobe width and the position of the done pulse for every wait code of every kind. A design that swapped the data and code base counts, or read the wrong field, would give lengths off by one or more. The table-lookup exception is run at code setting 00 and at a higher setting, to catch a design that drops the exception or applies it everywhere. A register rewrite in the middle of a cycle catches lengths read live instead of latched. A request made while busy, and a kind 11 request, both catch a controller that starts or switches cycles when it should not.

// File: rtl/extBusPkg.sv
package extBusPkg;
  localparam int REG_W     = 8;
  localparam int WAIT_BITS = 2;
  localparam int PF_BIT    = 7;
  localparam int BC_BIT    = 6;
  localparam int WR_LSB    = 4;
  localparam int RD_LSB    = 2;
  localparam int CODE_LSB  = 0;
  localparam int NUM_KINDS = 3;

  typedef enum logic [1:0] {
    KIND_WR   = 2'b00,
    KIND_RD   = 2'b01,
    KIND_CODE = 2'b10,
    KIND_NONE = 2'b11
  } cycKind_t;

  typedef struct packed {
    logic load;  // capture length, cycle starts next clock
    logic run;   // a cycle is in progress
  } ctlStrobe_t;
endpackage

// File: rtl/extBusCtrl.sv
module extBusCtrl
  import extBusPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  cycKind_t             reqKind,
  input  logic                 lastPeriod,
  output ctlStrobe_t           ctl,
  output logic                 idle,
  output logic                 done,
  output logic [NUM_KINDS-1:0] strobeVec
);
  typedef enum logic {ST_IDLE, ST_ACTIVE} state_t;

  state_t   state;
  cycKind_t kindQ;
  logic     accept;

  assign accept = (state == ST_IDLE) && reqValid && (reqKind != KIND_NONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      kindQ <= KIND_NONE;
    end else if (accept) begin
      state <= ST_ACTIVE;
      kindQ <= reqKind;
    end else if (state == ST_ACTIVE && lastPeriod) begin
      state <= ST_IDLE;
    end
  end

  assign ctl.load = accept;
  assign ctl.run  = (state == ST_ACTIVE);
  assign idle     = (state == ST_IDLE);
  assign done     = ctl.run && lastPeriod;

  for (genvar k = 0; k < NUM_KINDS; k++) begin : gStrobe
    assign strobeVec[k] = ctl.run && (kindQ == cycKind_t'(2'(k)));
  end

  AST_KIND_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.run && !lastPeriod) |=> (ctl.run && $stable(kindQ))) else $error("kind changed mid-cycle"); // R9
  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.run && !lastPeriod && reqValid) |=> $stable(kindQ)) else $error("request taken while busy"); // R7
endmodule

// File: rtl/extBusDatapath.sv
module extBusDatapath
  import extBusPkg::*;
#(
  parameter int                 DATA_BASE = 4,
  parameter int                 CODE_BASE = 3,
  parameter int                 TABLE_MIN = 4,
  parameter logic [REG_W-1:0]   RESET_VAL = 8'hEB
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [REG_W-1:0] cfgWrData,
  output logic [REG_W-1:0] cfgRdData,
  input  ctlStrobe_t       ctl,
  input  cycKind_t         reqKind,
  input  logic             reqTable,
  output logic             lastPeriod,
  output logic             prefetchEn,
  output logic             branchEn
);
  localparam int MAX_LEN = DATA_BASE + (1 << WAIT_BITS) - 1;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  logic [REG_W-1:0]     cfgReg;
  logic [WAIT_BITS-1:0] waitSel;
  logic [CNT_W-1:0]     baseLen;
  logic [CNT_W-1:0]     lenCalc;
  logic [CNT_W-1:0]     cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        cfgReg <= RESET_VAL;
    else if (cfgWrEn) cfgReg <= cfgWrData;
  end

  assign cfgRdData  = cfgReg;
  assign prefetchEn = cfgReg[PF_BIT];
  assign branchEn   = cfgReg[BC_BIT];

  always_comb begin
    unique case (reqKind)
      KIND_WR: begin waitSel = cfgReg[WR_LSB +: WAIT_BITS]; baseLen = CNT_W'(DATA_BASE); end
      KIND_RD: begin waitSel = cfgReg[RD_LSB +: WAIT_BITS]; baseLen = CNT_W'(DATA_BASE); end
      default: begin waitSel = cfgReg[CODE_LSB +: WAIT_BITS]; baseLen = CNT_W'(CODE_BASE); end
    endcase
    lenCalc = baseLen + CNT_W'(waitSel);
    if (reqKind == KIND_CODE && reqTable && lenCalc < CNT_W'(TABLE_MIN))
      lenCalc = CNT_W'(TABLE_MIN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   cnt <= '0;
    else if (ctl.load)           cnt <= lenCalc - CNT_W'(1);
    else if (ctl.run && cnt != 0) cnt <= cnt - CNT_W'(1);
  end

  assign lastPeriod = (cnt == '0);

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.run && !ctl.load && cnt != 0) |=> (cnt == $past(cnt) - CNT_W'(1))) else $error("length changed mid-cycle"); // R6
  AST_LOAD_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> (cnt >= CNT_W'(CODE_BASE - 1) && cnt <= CNT_W'(MAX_LEN - 1))) else $error("length out of range"); // R5
endmodule

// File: rtl/extBusTimer.sv
module extBusTimer
  import extBusPkg::*;
#(
  parameter int               DATA_BASE = 4,
  parameter int               CODE_BASE = 3,
  parameter int               TABLE_MIN = 4,
  parameter logic [REG_W-1:0] RESET_VAL = 8'hEB
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [REG_W-1:0] cfgWrData,
  output logic [REG_W-1:0] cfgRdData,
  input  logic             reqValid,
  input  logic [1:0]       reqKind,
  input  logic             reqTable,
  output logic             busIdle,
  output logic             wrStrobe,
  output logic             rdStrobe,
  output logic             codeStrobe,
  output logic             cycleDone,
  output logic             prefetchEn,
  output logic             branchCacheEn
);
  ctlStrobe_t           ctl;
  logic                 lastPeriod;
  logic [NUM_KINDS-1:0] strobeVec;
  cycKind_t             kindIn;

  assign kindIn = cycKind_t'(reqKind);

  extBusCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(kindIn),
    .lastPeriod(lastPeriod), .ctl(ctl), .idle(busIdle), .done(cycleDone),
    .strobeVec(strobeVec)
  );

  extBusDatapath #(
    .DATA_BASE(DATA_BASE), .CODE_BASE(CODE_BASE),
    .TABLE_MIN(TABLE_MIN), .RESET_VAL(RESET_VAL)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .ctl(ctl), .reqKind(kindIn), .reqTable(reqTable),
    .lastPeriod(lastPeriod), .prefetchEn(prefetchEn), .branchEn(branchCacheEn)
  );

  assign wrStrobe   = strobeVec[0];
  assign rdStrobe   = strobeVec[1];
  assign codeStrobe = strobeVec[2];

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({wrStrobe, rdStrobe, codeStrobe})) else $error("strobes overlap"); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    busIdle |-> !(wrStrobe || rdStrobe || codeStrobe || cycleDone)) else $error("activity while idle"); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    cycleDone |=> !cycleDone) else $error("done longer than one clock"); // R8
  AST_DONE_IN_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    cycleDone |-> $countones({wrStrobe, rdStrobe, codeStrobe}) == 1) else $error("done without strobe"); // R8
  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    cycleDone |=> busIdle) else $error("cycle did not end after done"); // R8
endmodule

// File: tb/sim_extBusTimer.sv
`timescale 1ns/1ps
module sim_extBusTimer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWrEn = 1'b0;
  logic [7:0] cfgWrData = '0;
  logic [7:0] cfgRdData;
  logic       reqValid = 1'b0;
  logic [1:0] reqKind = '0;
  logic       reqTable = 1'b0;
  logic       busIdle, wrStrobe, rdStrobe, codeStrobe, cycleDone;
  logic       prefetchEn, branchCacheEn;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  extBusTimer u0 (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .reqValid(reqValid), .reqKind(reqKind),
    .reqTable(reqTable), .busIdle(busIdle), .wrStrobe(wrStrobe),
    .rdStrobe(rdStrobe), .codeStrobe(codeStrobe), .cycleDone(cycleDone),
    .prefetchEn(prefetchEn), .branchCacheEn(branchCacheEn)
  );

  // cfg[14:7], kind[6:5], table[4], expected length[3:0]
  localparam int NV = 17;
  localparam logic [14:0] VEC [NV] = '{
    {8'h00, 2'd0, 1'b0, 4'd4}, {8'h00, 2'd1, 1'b0, 4'd4},
    {8'h00, 2'd2, 1'b0, 4'd3}, {8'h00, 2'd2, 1'b1, 4'd4},
    {8'h95, 2'd0, 1'b0, 4'd5}, {8'h95, 2'd1, 1'b0, 4'd5},
    {8'h95, 2'd2, 1'b1, 4'd4}, {8'h6A, 2'd0, 1'b0, 4'd6},
    {8'h6A, 2'd1, 1'b0, 4'd6}, {8'h6A, 2'd2, 1'b0, 4'd5},
    {8'h3F, 2'd0, 1'b0, 4'd7}, {8'h3F, 2'd1, 1'b0, 4'd7},
    {8'h3F, 2'd2, 1'b1, 4'd6}, {8'h3F, 2'd2, 1'b0, 4'd6},
    {8'h1C, 2'd0, 1'b0, 4'd5}, {8'h1C, 2'd1, 1'b0, 4'd7},
    {8'h1C, 2'd2, 1'b1, 4'd4}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writeCfg(input logic [7:0] v);
    @(negedge clk); cfgWrEn = 1'b1; cfgWrData = v;
    @(negedge clk); cfgWrEn = 1'b0;
  endtask

  // Starts a cycle and measures strobe width and done position.
  task automatic runCycle(input logic [1:0] kind, input bit tbl,
                          input bit midWr, input logic [7:0] midData,
                          input bit midReq, input logic [1:0] midKind,
                          output int len, output int doneAt, output int badStrobe);
    @(negedge clk); reqValid = 1'b1; reqKind = kind; reqTable = tbl;
    @(negedge clk); reqValid = 1'b0; reqTable = 1'b0;
    len = 0; doneAt = -1; badStrobe = 0;
    for (int i = 0; i < 20; i++) begin
      cfgWrEn = 1'b0; reqValid = 1'b0;
      if (!(wrStrobe || rdStrobe || codeStrobe)) break;
      len++;
      if ({codeStrobe, rdStrobe, wrStrobe} != (3'b001 << kind)) badStrobe++;
      if (cycleDone) begin
        if (doneAt != -1) badStrobe++;
        doneAt = len;
      end
      if (i == 1) begin
        if (midWr)  begin cfgWrEn = 1'b1; cfgWrData = midData; end
        if (midReq) begin reqValid = 1'b1; reqKind = midKind; end
      end
      @(negedge clk);
    end
    cfgWrEn = 1'b0; reqValid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int len, doneAt, bad;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cfgRdData == 8'hEB, "R1 reset value", cfgRdData, 8'hEB);
    chk(prefetchEn && branchCacheEn, "R1 enables after reset", {prefetchEn, branchCacheEn}, 3);
    chk(busIdle && !(wrStrobe || rdStrobe || codeStrobe || cycleDone), "R9 idle after reset", busIdle, 1);
    // reset-value lengths: write 6, read 6, code 6
    runCycle(2'd0, 1'b0, 1'b0, 8'h00, 1'b0, 2'd0, len, doneAt, bad);
    chk(len == 6, "R3 default write length", len, 6);
    runCycle(2'd1, 1'b0, 1'b0, 8'h00, 1'b0, 2'd0, len, doneAt, bad);
    chk(len == 6, "R4 default read length", len, 6);
    runCycle(2'd2, 1'b0, 1'b0, 8'h00, 1'b0, 2'd0, len, doneAt, bad);
    chk(len == 6, "R5 default code length", len, 6);

    // vector table
    for (int v = 0; v < NV; v++) begin
      logic [7:0] cfg;
      logic [1:0] kind;
      int expLen;
      cfg = VEC[v][14:7]; kind = VEC[v][6:5]; expLen = int'(VEC[v][3:0]);
      writeCfg(cfg);
      chk(cfgRdData == cfg, "R2 readback", cfgRdData, cfg);
      chk(prefetchEn == cfg[7] && branchCacheEn == cfg[6], "R2 enable bits",
          {prefetchEn, branchCacheEn}, cfg[7:6]);
      runCycle(kind, VEC[v][4], 1'b0, 8'h00, 1'b0, 2'd0, len, doneAt, bad);
      if (kind == 2'd0)      chk(len == expLen, "R3 write length", len, expLen);
      else if (kind == 2'd1) chk(len == expLen, "R4 read length", len, expLen);
      else                   chk(len == expLen, "R5 code length", len, expLen);
      chk(doneAt == expLen, "R8 done in last clock only", doneAt, expLen);
      chk(bad == 0, "R9 single held strobe", bad, 0);
    end

    // R6: rewrite mid-cycle, current length kept, next cycle uses new value
    writeCfg(8'h00);
    runCycle(2'd0, 1'b0, 1'b1, 8'h30, 1'b0, 2'd0, len, doneAt, bad);
    chk(len == 4, "R6 mid-cycle write ignored by current", len, 4);
    chk(cfgRdData == 8'h30, "R6 mid-cycle write stored", cfgRdData, 8'h30);
    runCycle(2'd0, 1'b0, 1'b0, 8'h00, 1'b0, 2'd0, len, doneAt, bad);
    chk(len == 7, "R6 new value on next cycle", len, 7);

    // R7: request while busy ignored
    runCycle(2'd1, 1'b0, 1'b0, 8'h00, 1'b1, 2'd2, len, doneAt, bad);
    chk(len == 4 && bad == 0, "R7 busy request ignored", len, 4);
    repeat (3) begin
      chk(busIdle && !(wrStrobe || rdStrobe || codeStrobe), "R7 no cycle after busy request", busIdle, 1);
      @(negedge clk);
    end

    // R7: kind 11 ignored
    reqValid = 1'b1; reqKind = 2'd3;
    @(negedge clk); reqValid = 1'b0;
    repeat (3) begin
      chk(busIdle && !(wrStrobe || rdStrobe || codeStrobe || cycleDone), "R7 kind 11 ignored", busIdle, 1);
      @(negedge clk);
    end

    // R1 again after a second reset
    rstN = 1'b0; @(negedge clk); rstN = 1'b1; @(negedge clk);
    chk(cfgRdData == 8'hEB, "R1 value after re-reset", cfgRdData, 8'hEB);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule